// File: doc/BRIEF.md
# Banked Shared Scratchpad with Conflict Replay

This block is an on-chip scratchpad that a group of eight lockstep lane processors share. Storage is split into sixteen single-ported banks of 256 words each. Each word is 32 bits wide, so the total is 16 KB. In one cycle a caller hands over a whole request group. Each lane in the group may carry a read or a write to a word address.

The block sends each lane request to a bank using the low address bits. Each bank performs at most one access per cycle, so lanes that land on different banks are served in the same cycle. When several lanes fall into one bank, the bank replays their accesses over successive cycles, lowest lane first. Reads of one identical word share a single access. While any lane of the group is still unserved, the block reports itself busy and takes no new group. Each lane gets its own completion strobe and read data one cycle after its bank access.

Top module: `banked_scratchpad`

## Requirements
- R1: While reset is held and right after it, `busy` is 0 and every bit of `rsp_valid` is 0.
- R2: A word address selects bank = address bits [3:0] and row = address bits [11:4]. A read returns the value last written to that same address, and different addresses keep independent values.
- R3: Enabled lanes whose addresses fall in eight different banks are all served in the first cycle after acceptance. Every `rsp_valid` bit of the group then rises together, and `busy` is high for exactly one cycle.
- R4: Lanes whose requests share a bank are granted one per cycle in ascending lane-index order. A write by a lower lane is therefore seen by a read from a higher lane in the same group, and a read by a lower lane still returns the old value.
- R5: Reads of the identical word address by several lanes are served by one bank access in the same cycle. This holds unless a lower-indexed lane has a still-pending write in that bank, in which case the later reads wait for their turn.
- R6: A group is accepted on a clock edge where `req_valid` is 1 and `busy` is 0. From that edge, `busy` stays 1 until the last enabled lane has been served. A `req_valid` presented while `busy` is 1 is ignored: it writes nothing and produces no response.
- R7: A lane served in grant cycle g (g = 0 is the cycle right after acceptance) shows `rsp_valid` for exactly one cycle, namely cycle g+1. Its `rsp_data` is registered with that strobe: the read word for a read, zero for a write.
- R8: A lane whose `lane_en` bit is 0 in an accepted group produces no `rsp_valid` and does not change memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Offers a request group; taken when `busy` is 0 |
| lane_en | input | 8 | Per-lane request enable |
| lane_we | input | 8 | Per-lane operation: 1 write, 0 read |
| lane_addr | input | 96 | Per-lane 12-bit word address, lane i at bits [12i+11:12i] |
| lane_wdata | input | 256 | Per-lane write word, lane i at bits [32i+31:32i] |
| busy | output | 1 | A group is in service; new groups are refused |
| rsp_valid | output | 8 | Per-lane one-cycle completion strobe |
| rsp_data | output | 256 | Per-lane read word (zero for writes), lane i at bits [32i+31:32i] |

## Verification
Take the acceptance edge as edge 0. A lane granted in cycle g has its strobe and data visible after edge g+1. For a group whose last grant falls in cycle G, `busy` is high in the windows after edges 0 through G, which is G+1 sampled cycles. For every group the bench writes the expected grant cycle of each lane from the bank and ordering rules. It then samples at the falling edge after each rising edge, recording the window in which each strobe first appears and how often it appears. Each lane's strobe must come in its computed window and exactly once, and the number of busy windows must equal the latest expected completion window. Read data is predicted by applying the lanes of each group to a reference array in ascending lane order.

// File: rtl/sp_pkg.sv
// Package: shared default sizing for the banked scratchpad.
// Assumes: the top module takes its parameter defaults from here.
package sp_pkg;
    localparam int SP_LANES      = 8;
    localparam int SP_BANKS      = 16;
    localparam int SP_BANK_WORDS = 256;
    localparam int SP_DATA_W     = 32;
endpackage

// File: rtl/sp_bank.sv
// Module: sp_bank
// One single-ported storage bank. It takes at most one access per cycle.
// A write lands at the clock edge. Read data is presented combinationally
// for the addressed row, and the lane response stage registers it.
// Assumes: the caller never asks the same bank for a read and a write in one cycle.
module sp_bank #(
    parameter  int WORDS  = 256,
    parameter  int DATA_W = 32,
    localparam int ROW_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [WORDS];

    // Commit a granted write at the clock edge.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[row] <= wdata;
        end
    end

    // Present the addressed word for a granted read.
    assign rdata = mem[row];

endmodule

// File: rtl/sp_bank_arbiter.sv
// Module: sp_bank_arbiter
// Grant logic for one bank. Among the pending lanes that map to this bank,
// the lowest-indexed lane wins. If the winner is a read, other pending reads
// of the same word join it, unless a lower lane still has a write pending
// in this bank.
// Assumes: pend only holds lanes that are not yet served.
module sp_bank_arbiter #(
    parameter  int LANES   = 8,
    parameter  int ADDR_W  = 12,
    parameter  int BANK_W  = 4,
    parameter  int BANK_ID = 0,
    localparam int LANE_W  = $clog2(LANES),
    localparam int ROW_W   = ADDR_W - BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  pend,
    input  logic [LANES-1:0]  we,
    input  logic [ADDR_W-1:0] addr [LANES],
    output logic [LANES-1:0]  grant,
    output logic              acc_en,
    output logic              acc_we,
    output logic [ROW_W-1:0]  acc_row,
    output logic [LANE_W-1:0] acc_lane
);

    logic [LANES-1:0] hit;
    logic [LANES-1:0] wr_below;
    logic             seen_wr;
    logic             found;

    // Find this bank's requesters, the winning lane, and the shared-read partners.
    always_comb begin
        hit      = '0;
        wr_below = '0;
        seen_wr  = 1'b0;
        found    = 1'b0;
        acc_lane = '0;
        for (int i = 0; i < LANES; i++) begin
            hit[i]      = pend[i] && (addr[i][BANK_W-1:0] == BANK_W'(BANK_ID));
            wr_below[i] = seen_wr;
            if (hit[i] && we[i]) begin
                seen_wr = 1'b1;
            end
            if (hit[i] && !found) begin
                found    = 1'b1;
                acc_lane = LANE_W'(i);
            end
        end
        grant = '0;
        for (int i = 0; i < LANES; i++) begin
            if (hit[i]) begin
                if (LANE_W'(i) == acc_lane) begin
                    grant[i] = 1'b1;
                end else if (!we[acc_lane] && !we[i] && !wr_below[i]
                             && (addr[i] == addr[acc_lane])) begin
                    grant[i] = 1'b1;
                end
            end
        end
        acc_en  = found;
        acc_we  = found && we[acc_lane];
        acc_row = addr[acc_lane][ADDR_W-1:BANK_W];
    end

    // R5: a multi-lane grant in one cycle is only ever a shared read.
    p_shared_is_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(grant) > 1) |-> !acc_we);

    // R4: grants go only to lanes still waiting.
    p_grant_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~pend) == '0);

endmodule

// File: rtl/sp_lane_rsp.sv
// Module: sp_lane_rsp
// Response register for one lane. It raises a one-cycle strobe in the cycle
// after the lane's bank access and captures the word from the selected bank,
// or zero when the lane wrote.
// Assumes: served is high for at most one cycle per request group.
module sp_lane_rsp #(
    parameter  int BANKS  = 16,
    parameter  int DATA_W = 32,
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              served,
    input  logic              is_write,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [DATA_W-1:0] bank_rdata [BANKS],
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);

    // Register the completion strobe and the lane's result word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= served;
            if (served) begin
                rsp_data <= is_write ? '0 : bank_rdata[bank_sel];
            end
        end
    end

    // R7: the result word only moves when the lane has been served.
    p_data_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !served |=> $stable(rsp_data));

endmodule

// File: rtl/banked_scratchpad.sv
// Module: banked_scratchpad
// Scratchpad shared by lockstep lanes, built from single-ported banks. It
// accepts one request group when idle, then replays the lanes bank by bank
// until every enabled lane has been served. busy stays high until then.
// Assumes: the caller holds a group on req_valid until busy is seen low.
module banked_scratchpad
    import sp_pkg::*;
#(
    parameter  int LANES      = SP_LANES,
    parameter  int BANKS      = SP_BANKS,
    parameter  int BANK_WORDS = SP_BANK_WORDS,
    parameter  int DATA_W     = SP_DATA_W,
    localparam int BANK_W     = $clog2(BANKS),
    localparam int ROW_W      = $clog2(BANK_WORDS),
    localparam int ADDR_W     = BANK_W + ROW_W,
    localparam int LANE_W     = $clog2(LANES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [LANES-1:0]         lane_en,
    input  logic [LANES-1:0]         lane_we,
    input  logic [LANES*ADDR_W-1:0]  lane_addr,
    input  logic [LANES*DATA_W-1:0]  lane_wdata,
    output logic                     busy,
    output logic [LANES-1:0]         rsp_valid,
    output logic [LANES*DATA_W-1:0]  rsp_data
);

    logic [LANES-1:0]  pend_q;
    logic [LANES-1:0]  we_q;
    logic [ADDR_W-1:0] addr_q  [LANES];
    logic [DATA_W-1:0] wdata_q [LANES];
    logic [LANES-1:0]  served;
    logic [LANES-1:0]  grant_by_bank [BANKS];
    logic [DATA_W-1:0] bank_rdata    [BANKS];
    logic              accept;

    assign busy   = |pend_q;
    assign accept = req_valid && !busy;

    // Track which lanes of the current group still wait for their bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (accept) begin
            pend_q <= lane_en;
        end else begin
            pend_q <= pend_q & ~served;
        end
    end

    // Capture the group's operations, addresses and write words on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q <= '0;
        end else if (accept) begin
            we_q <= lane_we;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_capture
        // Hold this lane's address and write word for the group's lifetime.
        always_ff @(posedge clk) begin
            if (accept) begin
                addr_q[l]  <= lane_addr[l*ADDR_W +: ADDR_W];
                wdata_q[l] <= lane_wdata[l*DATA_W +: DATA_W];
            end
        end
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic              acc_en;
        logic              acc_we;
        logic [ROW_W-1:0]  acc_row;
        logic [LANE_W-1:0] acc_lane;

        sp_bank_arbiter #(
            .LANES   (LANES),
            .ADDR_W  (ADDR_W),
            .BANK_W  (BANK_W),
            .BANK_ID (b)
        ) u_arb (
            .clk      (clk),
            .rst_n    (rst_n),
            .pend     (pend_q),
            .we       (we_q),
            .addr     (addr_q),
            .grant    (grant_by_bank[b]),
            .acc_en   (acc_en),
            .acc_we   (acc_we),
            .acc_row  (acc_row),
            .acc_lane (acc_lane)
        );

        sp_bank #(
            .WORDS  (BANK_WORDS),
            .DATA_W (DATA_W)
        ) u_mem (
            .clk   (clk),
            .wr_en (acc_en && acc_we),
            .row   (acc_row),
            .wdata (wdata_q[acc_lane]),
            .rdata (bank_rdata[b])
        );
    end

    // Merge the per-bank grants; each lane belongs to exactly one bank.
    always_comb begin
        served = '0;
        for (int b = 0; b < BANKS; b++) begin
            served = served | grant_by_bank[b];
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        sp_lane_rsp #(
            .BANKS  (BANKS),
            .DATA_W (DATA_W)
        ) u_rsp (
            .clk        (clk),
            .rst_n      (rst_n),
            .served     (served[l]),
            .is_write   (we_q[l]),
            .bank_sel   (addr_q[l][BANK_W-1:0]),
            .bank_rdata (bank_rdata),
            .rsp_valid  (rsp_valid[l]),
            .rsp_data   (rsp_data[l*DATA_W +: DATA_W])
        );
    end

    // R6: while busy, no lane may join the waiting set.
    p_no_new_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((pend_q & ~$past(pend_q)) == '0));

    // R4: every busy cycle serves at least one lane.
    p_progress_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (pend_q != $past(pend_q)));

    // R7: a lane that reports completion is no longer waiting.
    p_rsp_clears_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid & pend_q) == '0);

    // R1: reset leaves the block idle.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!busy && rsp_valid == '0));

endmodule

// File: tb/banked_scratchpad_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module banked_scratchpad_bench;
    localparam int LANES = 8;
    localparam int DW    = 32;
    localparam int AW    = 12;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                req_valid;
    logic [LANES-1:0]    lane_en, lane_we;
    logic [LANES*AW-1:0] lane_addr;
    logic [LANES*DW-1:0] lane_wdata;
    logic                busy;
    logic [LANES-1:0]    rsp_valid;
    logic [LANES*DW-1:0] rsp_data;

    always #5 clk = ~clk;

    banked_scratchpad u_banked_scratchpad (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .lane_en(lane_en),
        .lane_we(lane_we), .lane_addr(lane_addr), .lane_wdata(lane_wdata),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [DW-1:0]    model [4096];
    logic [LANES-1:0] g_en, g_we;
    logic [AW-1:0]    g_addr [LANES];
    logic [DW-1:0]    g_wd   [LANES];
    int               exp_cyc [LANES];
    logic [DW-1:0]    exp_dat [LANES];

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic clear_group();
        g_en = '0; g_we = '0;
        for (int i = 0; i < LANES; i++) begin
            g_addr[i] = '0; g_wd[i] = '0; exp_cyc[i] = 0;
        end
    endtask

    // Issue the staged group, optionally offer a ghost group while busy, and check it.
    task automatic run_group(input string tag, input bit inject);
        int maxc, busy_cnt;
        int got_cyc [LANES];
        int got_cnt [LANES];
        logic [DW-1:0] got_dat [LANES];
        maxc = 0; busy_cnt = 0;
        for (int i = 0; i < LANES; i++) begin
            got_cyc[i] = 0; got_cnt[i] = 0; got_dat[i] = '0;
            if (exp_cyc[i] > maxc) maxc = exp_cyc[i];
            if (g_en[i]) begin
                if (g_we[i]) begin
                    exp_dat[i] = '0;
                    model[g_addr[i]] = g_wd[i];
                end else begin
                    exp_dat[i] = model[g_addr[i]];
                end
            end
        end
        @(negedge clk);
        req_valid = 1'b1; lane_en = g_en; lane_we = g_we;
        for (int i = 0; i < LANES; i++) begin
            lane_addr[i*AW +: AW]  = g_addr[i];
            lane_wdata[i*DW +: DW] = g_wd[i];
        end
        @(posedge clk);
        for (int idx = 0; idx <= maxc + 3; idx++) begin
            @(negedge clk);
            if (busy) busy_cnt++;
            for (int i = 0; i < LANES; i++) begin
                if (rsp_valid[i]) begin
                    got_cnt[i]++;
                    if (got_cnt[i] == 1) begin
                        got_cyc[i] = idx;
                        got_dat[i] = rsp_data[i*DW +: DW];
                    end
                end
            end
            if (idx == 0 && inject) begin
                lane_en = 8'h01; lane_we = 8'h01;
                lane_addr[AW-1:0] = 12'd102;
                lane_wdata[DW-1:0] = 32'hDEAD_BEEF;
            end else begin
                req_valid = 1'b0;
            end
        end
        req_valid = 1'b0;
        chk(busy_cnt == maxc, $sformatf("%s busy windows", tag), busy_cnt, maxc);
        for (int i = 0; i < LANES; i++) begin
            if (exp_cyc[i] == 0) begin
                chk(got_cnt[i] == 0, $sformatf("%s lane%0d no response (R8)", tag, i), got_cnt[i], 0);
            end else begin
                chk(got_cnt[i] == 1, $sformatf("%s lane%0d strobe count (R7)", tag, i), got_cnt[i], 1);
                chk(got_cyc[i] == exp_cyc[i], $sformatf("%s lane%0d completion cycle", tag, i), got_cyc[i], exp_cyc[i]);
                chk(got_dat[i] == exp_dat[i], $sformatf("%s lane%0d data", tag, i), got_dat[i], exp_dat[i]);
            end
        end
    endtask

    // R1: idle outputs during and after reset.
    task automatic t_reset();
        rst_n = 1'b0; req_valid = 1'b0; lane_en = '0; lane_we = '0;
        lane_addr = '0; lane_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy, "R1 busy in reset", busy, 0);
        chk(rsp_valid == '0, "R1 rsp_valid in reset", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && rsp_valid == '0, "R1 idle after reset", {busy, rsp_valid}, 0);
    endtask

    // R3, R7: eight writes to eight banks finish together.
    task automatic t_parallel_write();
        clear_group();
        for (int i = 0; i < LANES; i++) begin
            g_en[i] = 1; g_we[i] = 1; g_addr[i] = AW'(i * 17);
            g_wd[i] = 32'hA000_0000 + i; exp_cyc[i] = 1;
        end
        run_group("R3 parallel write", 0);
    endtask

    // R2, R3: parallel read-back of distinct banks and rows.
    task automatic t_parallel_read();
        clear_group();
        for (int i = 0; i < LANES; i++) begin
            g_en[i] = 1; g_addr[i] = AW'(((7 - i) * 17)); exp_cyc[i] = 1;
        end
        run_group("R2 R3 parallel read", 0);
    endtask

    // R4, R6: all lanes write one bank; a ghost group is offered while busy.
    task automatic t_conflict_write();
        clear_group();
        for (int i = 0; i < LANES; i++) begin
            g_en[i] = 1; g_we[i] = 1; g_addr[i] = AW'(5 + 16 * i);
            g_wd[i] = 32'hB000_0000 + i; exp_cyc[i] = i + 1;
        end
        run_group("R4 R6 conflict write", 1);
    endtask

    // R2, R4: reversed read-back of one bank's rows.
    task automatic t_conflict_read();
        clear_group();
        for (int i = 0; i < LANES; i++) begin
            g_en[i] = 1; g_addr[i] = AW'(5 + 16 * (7 - i)); exp_cyc[i] = i + 1;
        end
        run_group("R2 R4 conflict read", 0);
    endtask

    // R5: one word read by every lane in a single access.
    task automatic t_broadcast();
        clear_group();
        for (int i = 0; i < LANES; i++) begin
            g_en[i] = 1; g_addr[i] = 12'd5; exp_cyc[i] = 1;
        end
        run_group("R5 broadcast", 0);
    endtask

    // R5, R4: two words in one bank, interleaved lanes.
    task automatic t_two_words();
        clear_group();
        for (int i = 0; i < LANES; i++) begin
            g_en[i] = 1; g_addr[i] = (i % 2 == 0) ? 12'd21 : 12'd5;
            exp_cyc[i] = (i % 2 == 0) ? 1 : 2;
        end
        run_group("R5 R4 two words", 0);
    endtask

    // R4, R5: reads and writes to one word keep lane order.
    task automatic t_hazard();
        clear_group();
        g_en[0] = 1; g_addr[0] = 12'd17; exp_cyc[0] = 1;
        g_en[1] = 1; g_addr[1] = 12'd34; exp_cyc[1] = 1;
        g_en[2] = 1; g_we[2] = 1; g_addr[2] = 12'd34; g_wd[2] = 32'h0000_C0DE; exp_cyc[2] = 2;
        g_en[5] = 1; g_addr[5] = 12'd34; exp_cyc[5] = 3;
        g_en[6] = 1; g_we[6] = 1; g_addr[6] = 12'd34; g_wd[6] = 32'h0000_C1DE; exp_cyc[6] = 4;
        g_en[7] = 1; g_addr[7] = 12'd34; exp_cyc[7] = 5;
        run_group("R4 R5 ordered hazard", 0);
    endtask

    // R8: disabled lanes neither answer nor write.
    task automatic t_disabled();
        clear_group();
        g_en[0] = 1; g_we[0] = 1; g_addr[0] = 12'd17; g_wd[0] = 32'h0000_00E1; exp_cyc[0] = 1;
        g_we[1] = 1; g_addr[1] = 12'd51; g_wd[1] = 32'h0BAD_0BAD;
        g_addr[3] = 12'd68;
        run_group("R8 disabled lanes", 0);
    endtask

    // R6, R8: read back words that the ghost group and a disabled lane could have hit.
    task automatic t_readback_untouched();
        clear_group();
        g_en[0] = 1; g_addr[0] = 12'd17;  exp_cyc[0] = 1;
        g_en[3] = 1; g_addr[3] = 12'd51;  exp_cyc[3] = 1;
        g_en[6] = 1; g_addr[6] = 12'd102; exp_cyc[6] = 1;
        run_group("R6 R8 untouched words", 0);
    endtask

    initial begin
        t_reset();
        t_parallel_write();
        t_parallel_read();
        t_conflict_write();
        t_conflict_read();
        t_broadcast();
        t_two_words();
        t_hazard();
        t_disabled();
        t_readback_untouched();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule